// File: doc/BRIEF.md
# Oversampled Asynchronous Serial DAC Word Receiver

This block takes DAC codes over a single idle-high serial line, the way a UART would, and uses a local clock that runs at a fixed multiple of the bit rate. It waits for a falling edge. It checks at mid-bit that the start bit is really low. It then samples each data bit once per bit time, most significant bit first, and finally reads the stop bit. A good stop bit copies the assembled word into the DAC code register and gives a one-cycle load strobe, so the update needs no external latch edge.

A low stop bit is a framing error. In that case the register keeps its old value and the error output goes high for one bit time. The receiver then waits until the line has returned high before it looks for a new start bit. Reception works only while the mode-enable input is held high. The 2-flop input synchronizer adds a fixed latency that does not change any of the relative sample points.

Top module: `async_dac_rx`

## Requirements
- R1: After reset the code register `dac_word` is 0, `load_pulse` is 0 and `ferr_out` is 0.
- R2: The receiver samples a frame of one low start bit, DATA_W data bits sent MSB first, and one high stop bit in the middle of each bit. The frame loads the data bits into `dac_word` and raises `load_pulse` for exactly one clock. `dac_word` changes only in a cycle where `load_pulse` is high.
- R3: The receiver accepts frames sent back to back, where the next start bit begins right after the previous stop bit, and loads each of them in order.
- R4: A low excursion on the line that is shorter than half a bit time is rejected at the mid-bit start check. It causes no load and no error, and a frame that follows it is received correctly.
- R5: A stop bit sampled low leaves `dac_word` unchanged and gives no load. Instead `ferr_out` goes high for exactly OVS consecutive clocks.
- R6: After a framing error, the receiver starts no frame while the line stays low. It hunts for a start bit only after the line has been seen high.
- R7: While `async_en` is low, the receiver ignores the line and resets to idle. There is no load and no error pulse.
- R8: `load_pulse` and `ferr_out` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Active-low reset |
| async_en | input | 1 | Mode enable; held high for asynchronous reception |
| rx_line | input | 1 | Serial data input, idle high |
| dac_word | output | DATA_W | DAC code register |
| load_pulse | output | 1 | One-cycle strobe when `dac_word` is updated |
| ferr_out | output | 1 | Framing error pulse, OVS clocks long |

## Verification
The bench uses the default values DATA_W=16 and OVS=16, so each frame is 288 clocks. This keeps whole runs of back-to-back frames, a framing error followed by a long stretch of low line, and glitches of a few clocks well inside the cycle budget. With 16 data bits, the test words can be alternating patterns, all ones and all zeros, which show any reversal of bit order or an off-by-one in the bit count. With OVS at 16, the length of the error pulse and the mid-bit start check at clock 8 differ clearly from a glitch that lasts only 3 clocks.

// File: rtl/async_dac_rx.sv
module async_dac_rx #(
  parameter int DATA_W = 16,
  parameter int OVS    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_en,
  input  logic              rx_line,
  output logic [DATA_W-1:0] dac_word,
  output logic              load_pulse,
  output logic              ferr_out
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_ERR, S_WAIT} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bit_idx;
  logic [DATA_W-1:0] shreg;
  logic [SYNC-1:0]  sync_q;
  logic             rx_d;
  logic             rx_s;

  assign rx_s     = sync_q[SYNC-1];
  assign ferr_out = (state == S_ERR);

  wire bit_end  = (cnt == CW'(OVS-1));
  wire half_end = (cnt == CW'(HALF-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      dac_word   <= '0;
      load_pulse <= 1'b0;
      sync_q     <= '1;
      rx_d       <= 1'b1;
    end else begin
      sync_q     <= {sync_q[SYNC-2:0], rx_line};
      rx_d       <= rx_s;
      load_pulse <= 1'b0;
      if (!async_en) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (rx_d && !rx_s) state <= S_START;
          end
          S_START: begin
            if (half_end) begin
              cnt     <= '0;
              bit_idx <= '0;
              state   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              cnt   <= '0;
              shreg <= {shreg[DATA_W-2:0], rx_s};
              if (bit_idx == BW'(DATA_W-1)) state <= S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              cnt <= '0;
              if (rx_s) begin
                dac_word   <= shreg;
                load_pulse <= 1'b1;
                state      <= S_IDLE;
              end else begin
                state <= S_ERR;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ERR: begin
            if (bit_end) begin
              cnt   <= '0;
              state <= S_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAIT: begin
            cnt <= '0;
            if (rx_s) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_dac_rx_checker.sv
module async_dac_rx_checker #(
  parameter int DATA_W = 16,
  parameter int OVS    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              async_en,
  input logic [DATA_W-1:0] dac_word,
  input logic              load_pulse,
  input logic              ferr_out
);
  localparam int RW = $clog2(OVS + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (ferr_out) run <= run + 1'b1;
    else run <= '0;
  end

  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  assert_word_only_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_word) |-> load_pulse);

  assert_err_not_too_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_out |-> (run < RW'(OVS)));

  assert_err_full_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ferr_out) && $past(async_en)) |-> (run == RW'(OVS)));

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !async_en |=> (!load_pulse && !ferr_out));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pulse && ferr_out));
endmodule

bind async_dac_rx async_dac_rx_checker #(.DATA_W(DATA_W), .OVS(OVS)) u_chk (
  .clk(clk), .rst_n(rst_n), .async_en(async_en), .dac_word(dac_word),
  .load_pulse(load_pulse), .ferr_out(ferr_out));

// File: tb/tb_async_dac_rx.sv
`timescale 1ns/1ps
module tb_async_dac_rx;
  localparam int DATA_W = 16;
  localparam int OVS    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_en = 1'b0;
  logic rx_line = 1'b1;
  logic [DATA_W-1:0] dac_word;
  logic load_pulse, ferr_out;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] exp_q[$];
  int err_expected = 0;
  int err_seen = 0;
  int run = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_dac_rx #(.DATA_W(DATA_W), .OVS(OVS)) dut (
    .clk(clk), .rst_n(rst_n), .async_en(async_en), .rx_line(rx_line),
    .dac_word(dac_word), .load_pulse(load_pulse), .ferr_out(ferr_out));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DATA_W-1:0] w, input logic stop, input bit expect_load);
    if (expect_load) exp_q.push_back(w);
    line_hold(1'b0, OVS);
    for (int i = DATA_W-1; i >= 0; i--) line_hold(w[i], OVS);
    line_hold(stop, OVS);
  endtask

  always @(negedge clk) begin
    if (rst_n && load_pulse) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R4/R6/R7 unexpected load", {16'h0, dac_word}, 32'h0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check(dac_word == e, "R2/R3 loaded word", {16'h0, dac_word}, {16'h0, e});
      end
      check(!ferr_out, "R8 exclusive", 32'(ferr_out), 32'h0);
    end
    if (rst_n && ferr_out) run++;
    else if (run != 0) begin
      err_seen++;
      check(run == OVS, "R5 error pulse length", run, OVS);
      run = 0;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dac_word == '0, "R1 reset word", {16'h0, dac_word}, 32'h0);
    check(!load_pulse, "R1 reset load", 32'(load_pulse), 32'h0);
    check(!ferr_out, "R1 reset error", 32'(ferr_out), 32'h0);
    rst_n = 1'b1;
    line_hold(1'b1, 20);

    // R7: mode off, a full frame with a bad stop must do nothing
    send_frame(16'h1234, 1'b0, 1'b0);
    line_hold(1'b1, 40);
    check(dac_word == '0, "R7 ignored while disabled", {16'h0, dac_word}, 32'h0);
    check(err_seen == 0, "R7 no error while disabled", err_seen, 0);

    async_en = 1'b1;
    line_hold(1'b1, 20);

    // R2 single frame
    send_frame(16'hA5C3, 1'b1, 1'b1);
    line_hold(1'b1, 20);
    check(dac_word == 16'hA5C3, "R2 single frame", {16'h0, dac_word}, 32'hA5C3);

    // R3 back to back
    send_frame(16'h8001, 1'b1, 1'b1);
    send_frame(16'hFFFF, 1'b1, 1'b1);
    send_frame(16'h0000, 1'b1, 1'b1);
    send_frame(16'h5AAA, 1'b1, 1'b1);
    line_hold(1'b1, 20);
    check(exp_q.size() == 0, "R3 all back-to-back loaded", exp_q.size(), 0);
    check(dac_word == 16'h5AAA, "R3 last word", {16'h0, dac_word}, 32'h5AAA);

    // R4 glitch then valid frame
    line_hold(1'b0, 3);
    line_hold(1'b1, 3 * OVS);
    check(dac_word == 16'h5AAA, "R4 glitch no load", {16'h0, dac_word}, 32'h5AAA);
    check(err_seen == 0, "R4 glitch no error", err_seen, 0);
    send_frame(16'h3C3C, 1'b1, 1'b1);
    line_hold(1'b1, 20);
    check(dac_word == 16'h3C3C, "R4 frame after glitch", {16'h0, dac_word}, 32'h3C3C);

    // R5/R6 bad stop, then line held low for a long time
    send_frame(16'h0F0F, 1'b0, 1'b0);
    err_expected++;
    line_hold(1'b0, 5 * OVS);
    check(err_seen == err_expected, "R5 one error pulse", err_seen, err_expected);
    check(dac_word == 16'h3C3C, "R5 word kept", {16'h0, dac_word}, 32'h3C3C);
    line_hold(1'b1, 2 * OVS);
    check(dac_word == 16'h3C3C, "R6 no frame from low line", {16'h0, dac_word}, 32'h3C3C);
    send_frame(16'hC001, 1'b1, 1'b1);
    line_hold(1'b1, 20);
    check(dac_word == 16'hC001, "R6 recovery frame", {16'h0, dac_word}, 32'hC001);

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    check(err_seen == err_expected, "R5 total errors", err_seen, err_expected);
    done = 1;
    finish_run();
  end
endmodule